// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small, fully associative store of whole cache lines that sits behind a direct-mapped cache. Its only contents are lines that the main cache threw out when it missed. When the main cache misses, it sends one request that carries the missing line address. If a line is being displaced from the main cache at the same time, the request carries that line too (its address, dirty bit and data). All entries are compared against the requested address in the same cycle.

On a match, the stored line is returned to the main cache. The displaced main-cache line takes over the matching entry, so the two lines trade places and memory is not touched. On no match, the response says the request must go on to memory, and the displaced line is written into the store. When an entry holding modified data has to make room, that entry is sent out on a writeback channel.

The request, response and writeback channels use valid/ready handshakes. A transfer happens on a rising clock edge where both valid and ready are high. The block processes one request at a time. It lowers `req_ready` while a response or a writeback is still waiting to be taken, so a slow consumer on either output channel stalls new lookups. Once a response or writeback is raised, it holds its payload unchanged until it is taken. The duplicate-match flag is a plain combinational status pin.

Top module: `victim_cache`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` and `wb_valid` are 0, `req_ready` is 1, and a first lookup misses.
- R2: An accepted request whose `req_addr` equals the tag of a valid entry produces, on the next rising edge, `rsp_valid`=1 and `rsp_hit`=1, with that entry's data on `rsp_data` and its dirty bit on `rsp_dirty`.
- R3: On a hit, the matching entry is overwritten by the accompanying displaced line (tag `ev_addr`, `ev_dirty`, `ev_data`) when `ev_valid`=1, or freed when `ev_valid`=0. A hit never raises `wb_valid`.
- R4: On a miss, the response has `rsp_hit`=0, `rsp_dirty`=0 and `rsp_data`=0. When `ev_valid`=1, the displaced line is written into the lowest-numbered free entry.
- R5: On a miss with `ev_valid`=1 and every entry valid, the new line replaces the entry selected by a round-robin replacement pointer. The pointer starts at entry 0 after reset and advances by one (wrapping after the last entry) only on such a replacement.
- R6: An entry overwritten under R5 whose dirty bit is set is sent out on the next rising edge with `wb_valid`=1, its tag on `wb_addr` and its data on `wb_data`. A clean entry overwritten this way is dropped with no writeback.
- R7: `req_ready` is 0 while `rsp_valid` or `wb_valid` is 1. Each output channel holds its payload stable until the edge where its ready input is high, and `valid` drops after that edge.
- R8: A miss with `ev_valid`=0 leaves the store unchanged and produces no writeback.
- R9: `dup_err` is 1 while `req_valid` is 1 and more than one valid entry matches `req_addr`, and 0 while exactly one or no entry matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | VC_ADDR_W | Line address missed by the main cache |
| ev_valid | input | 1 | A line is displaced from the main cache with this request |
| ev_addr | input | VC_ADDR_W | Line address of the displaced line |
| ev_dirty | input | 1 | Displaced line holds modified data |
| ev_data | input | VC_DATA_W | Data of the displaced line |
| rsp_valid | output | 1 | Lookup result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | 1 when the line was found in the store |
| rsp_dirty | output | 1 | Dirty bit of the returned line |
| rsp_data | output | VC_DATA_W | Returned line data (zero on a miss) |
| wb_valid | output | 1 | Dirty line to be written to memory |
| wb_ready | input | 1 | Memory side takes the writeback |
| wb_addr | output | VC_ADDR_W | Line address of the writeback |
| wb_data | output | VC_DATA_W | Data of the writeback |
| dup_err | output | 1 | More than one entry matches the current request |

## Verification
The lookups draw on a small pool of conflicting line addresses, so hits, misses, swaps and full-store replacements all occur often. Directed sequences add coverage in several ways:
- A lookup into an empty store separates a genuine miss from stale state left after reset.
- Filling the store and then adding lines tells the lowest-free-slot rule apart from the round-robin pointer, and clean victims apart from dirty ones.
- Hits with and without a displaced line distinguish a swap from a plain removal.
- Responses and writebacks held back for a few cycles show whether payloads stay stable and lookups stall.
- A deliberately planted duplicate tag shows whether the error flag separates a double match from a single one.

// File: rtl/vc_pkg.sv
package vc_pkg;
  parameter int VC_ADDR_W = 26;
  parameter int VC_DATA_W = 128;

  typedef struct packed {
    logic                 valid;
    logic                 dirty;
    logic [VC_ADDR_W-1:0] tag;
    logic [VC_DATA_W-1:0] data;
  } vc_line_t;
endpackage

// File: rtl/vc_match.sv
module vc_match
  import vc_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  vc_line_t             lines   [ENTRIES],
  input  logic [VC_ADDR_W-1:0] key,
  output logic [ENTRIES-1:0]   hit_vec,
  output logic                 any_hit,
  output logic [IDX_W-1:0]     hit_idx,
  output logic                 multi
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = lines[g].valid && (lines[g].tag == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign any_hit = |hit_vec;
  assign multi   = !$onehot0(hit_vec);
endmodule

// File: rtl/vc_alloc.sv
module vc_alloc #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               ins_en,
  output logic [IDX_W-1:0]   slot,
  output logic               full
);
  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;

  assign full = &valid_vec;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign slot = full ? rr_ptr : free_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (ins_en && full) begin
      rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  assert_free_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en && !full |-> !valid_vec[slot]);
endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import vc_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VC_ADDR_W-1:0] req_addr,
  input  logic                 ev_valid,
  input  logic [VC_ADDR_W-1:0] ev_addr,
  input  logic                 ev_dirty,
  input  logic [VC_DATA_W-1:0] ev_data,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_hit,
  output logic                 rsp_dirty,
  output logic [VC_DATA_W-1:0] rsp_data,
  output logic                 wb_valid,
  input  logic                 wb_ready,
  output logic [VC_ADDR_W-1:0] wb_addr,
  output logic [VC_DATA_W-1:0] wb_data,
  output logic                 dup_err
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  vc_line_t           store [ENTRIES];
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] hit_vec;
  logic               any_hit;
  logic               multi;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   ins_slot;
  logic               full;
  logic               accept;
  logic               ins_en;
  vc_line_t           new_line;
  vc_line_t           old_line;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_valid
    assign valid_vec[g] = store[g].valid;
  end

  vc_match #(.ENTRIES(ENTRIES)) u_match (
    .lines   (store),
    .key     (req_addr),
    .hit_vec (hit_vec),
    .any_hit (any_hit),
    .hit_idx (hit_idx),
    .multi   (multi)
  );

  assign req_ready = !rsp_valid && !wb_valid;
  assign accept    = req_valid && req_ready;
  assign ins_en    = accept && !any_hit && ev_valid;
  assign dup_err   = req_valid && multi;

  vc_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .ins_en    (ins_en),
    .slot      (ins_slot),
    .full      (full)
  );

  always_comb begin
    new_line.valid = ev_valid;
    new_line.dirty = ev_dirty;
    new_line.tag   = ev_addr;
    new_line.data  = ev_data;
    old_line       = store[ins_slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) store[i] <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_data  <= '0;
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
      wb_data   <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (wb_valid && wb_ready)   wb_valid  <= 1'b0;
      if (accept) begin
        rsp_valid <= 1'b1;
        if (any_hit) begin
          rsp_hit          <= 1'b1;
          rsp_dirty        <= store[hit_idx].dirty;
          rsp_data         <= store[hit_idx].data;
          store[hit_idx]   <= new_line;
        end else begin
          rsp_hit   <= 1'b0;
          rsp_dirty <= 1'b0;
          rsp_data  <= '0;
          if (ev_valid) begin
            store[ins_slot] <= new_line;
            if (old_line.valid && old_line.dirty) begin
              wb_valid <= 1'b1;
              wb_addr  <= old_line.tag;
              wb_data  <= old_line.data;
            end
          end
        end
      end
    end
  end

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  assert_hit_no_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && any_hit |=> !wb_valid);

  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_hit)
      && $stable(rsp_dirty));

  assert_wb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));

  assert_nomiss_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !any_hit && !ev_valid |=> !wb_valid);
endmodule

// File: tb/victim_cache_bench.sv
module victim_cache_bench;
  import vc_pkg::*;
  localparam int N = 4;
  localparam int POOL = 10;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [VC_ADDR_W-1:0] req_addr = '0;
  logic                 ev_valid = 1'b0;
  logic [VC_ADDR_W-1:0] ev_addr = '0;
  logic                 ev_dirty = 1'b0;
  logic [VC_DATA_W-1:0] ev_data = '0;
  logic                 rsp_valid, rsp_hit, rsp_dirty;
  logic                 rsp_ready = 1'b0;
  logic [VC_DATA_W-1:0] rsp_data;
  logic                 wb_valid;
  logic                 wb_ready = 1'b0;
  logic [VC_ADDR_W-1:0] wb_addr;
  logic [VC_DATA_W-1:0] wb_data;
  logic                 dup_err;

  always #4 clk = ~clk;

  victim_cache #(.ENTRIES(N)) u_victim_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_dirty(ev_dirty), .ev_data(ev_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_dirty(rsp_dirty), .rsp_data(rsp_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
    .dup_err(dup_err)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference model of the store
  bit                   m_v  [N];
  bit                   m_d  [N];
  logic [VC_ADDR_W-1:0] m_a  [N];
  logic [VC_DATA_W-1:0] m_dt [N];
  int                   m_ptr = 0;

  function automatic logic [VC_ADDR_W-1:0] pool_addr(int k);
    return VC_ADDR_W'(32'h40 + k * 32'h400);
  endfunction

  function automatic int find(logic [VC_ADDR_W-1:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == a) return i;
    return -1;
  endfunction

  function automatic int ins_slot_of();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    return m_ptr;
  endfunction

  function automatic logic [VC_DATA_W-1:0] rand_line();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic chk(bit ok, string req, logic [VC_DATA_W-1:0] act, logic [VC_DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(logic [VC_ADDR_W-1:0] a, bit evv, logic [VC_ADDR_W-1:0] ea,
                        bit ed, logic [VC_DATA_W-1:0] edt, int hold);
    int hi, sl;
    bit e_hit, e_dirty, e_wb;
    logic [VC_DATA_W-1:0] e_data, e_wbd;
    logic [VC_ADDR_W-1:0] e_wba;
    hi = find(a);
    e_hit = (hi >= 0);
    e_dirty = e_hit ? m_d[hi] : 1'b0;
    e_data = e_hit ? m_dt[hi] : '0;
    e_wb = 1'b0; e_wba = '0; e_wbd = '0;
    sl = -1;
    if (e_hit) sl = hi;
    else if (evv) begin
      sl = ins_slot_of();
      if (m_v[sl] && m_d[sl]) begin
        e_wb = 1'b1; e_wba = m_a[sl]; e_wbd = m_dt[sl];
      end
    end

    @(negedge clk);
    req_valid = 1'b1; req_addr = a; ev_valid = evv; ev_addr = ea;
    ev_dirty = ed; ev_data = edt;
    #1;
    chk(dup_err == 1'b0, "R9 single match flag", VC_DATA_W'(dup_err), 0);
    chk(req_ready == 1'b1, "R7 ready when idle", VC_DATA_W'(req_ready), 1);
    @(posedge clk); #1;
    req_valid = 1'b0; ev_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R2 response after one edge", VC_DATA_W'(rsp_valid), 1);
    chk(rsp_hit == e_hit, e_hit ? "R2 hit flag" : "R4 miss flag", VC_DATA_W'(rsp_hit), VC_DATA_W'(e_hit));
    chk(rsp_data == e_data, e_hit ? "R2 hit data" : "R4 miss data zero", rsp_data, e_data);
    chk(rsp_dirty == e_dirty, e_hit ? "R2 dirty bit" : "R4 miss dirty zero", VC_DATA_W'(rsp_dirty), VC_DATA_W'(e_dirty));
    chk(wb_valid == e_wb, e_hit ? "R3 no writeback on hit" : (evv ? "R6 writeback valid" : "R8 no writeback"),
        VC_DATA_W'(wb_valid), VC_DATA_W'(e_wb));
    if (e_wb) begin
      chk(wb_addr == e_wba, "R6 writeback address", VC_DATA_W'(wb_addr), VC_DATA_W'(e_wba));
      chk(wb_data == e_wbd, "R6 writeback data", wb_data, e_wbd);
    end
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R7 stall while pending", VC_DATA_W'(req_ready), 0);
      chk(rsp_valid && rsp_data == e_data && rsp_hit == e_hit, "R7 response held", rsp_data, e_data);
      if (e_wb) chk(wb_valid && wb_data == e_wbd && wb_addr == e_wba, "R7 writeback held", wb_data, e_wbd);
    end
    @(negedge clk);
    rsp_ready = 1'b1; wb_ready = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0; wb_ready = 1'b0;
    chk(!rsp_valid && !wb_valid, "R7 valid drops after transfer", VC_DATA_W'({rsp_valid, wb_valid}), 0);
    chk(req_ready == 1'b1, "R7 ready returns", VC_DATA_W'(req_ready), 1);

    if (sl >= 0) begin
      if (!e_hit && m_v[sl] && sl == m_ptr && ins_slot_of() == m_ptr && m_v[0] && m_v[1] && m_v[2] && m_v[3])
        m_ptr = (m_ptr + 1) % N;
      m_v[sl] = evv; m_d[sl] = ed; m_a[sl] = ea; m_dt[sl] = edt;
    end
  endtask

  // pick a displaced-line address absent from the store and different from the lookup
  function automatic logic [VC_ADDR_W-1:0] pick_ev(logic [VC_ADDR_W-1:0] a);
    logic [VC_ADDR_W-1:0] c;
    for (int t = 0; t < 64; t++) begin
      c = pool_addr(int'($urandom_range(POOL - 1, 0)));
      if (c != a && find(c) < 0) return c;
    end
    for (int k = 0; k < POOL; k++) begin
      c = pool_addr(k);
      if (c != a && find(c) < 0) return c;
    end
    return VC_ADDR_W'(32'h3FFF);
  endfunction

  initial begin
    int unsigned seed;
    logic [VC_ADDR_W-1:0] a, x;
    int dsl;
    seed = $urandom(32'd8086);
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_d[i] = 0; m_a[i] = '0; m_dt[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready && !rsp_valid && !wb_valid, "R1 reset state",
        VC_DATA_W'({req_ready, rsp_valid, wb_valid}), VC_DATA_W'(3'b100));
    rst_n = 1'b1;
    // R1 / R8: first lookup into empty store, nothing to insert
    do_req(pool_addr(0), 1'b0, '0, 1'b0, '0, 0);
    // R4: fill free slots in order, mixed dirty bits
    do_req(pool_addr(0), 1'b1, pool_addr(1), 1'b1, rand_line(), 0);
    do_req(pool_addr(0), 1'b1, pool_addr(2), 1'b0, rand_line(), 0);
    do_req(pool_addr(0), 1'b1, pool_addr(3), 1'b1, rand_line(), 1);
    do_req(pool_addr(0), 1'b1, pool_addr(4), 1'b0, rand_line(), 0);
    // R5 / R6: full store, round-robin replacement (dirty then clean victim)
    do_req(pool_addr(0), 1'b1, pool_addr(5), 1'b1, rand_line(), 2);
    do_req(pool_addr(0), 1'b1, pool_addr(6), 1'b0, rand_line(), 0);
    // R2 / R3: hit with swap, then hit with no displaced line (frees entry)
    do_req(pool_addr(3), 1'b1, pool_addr(7), 1'b1, rand_line(), 3);
    do_req(pool_addr(4), 1'b0, '0, 1'b0, '0, 0);
    // R4: freed entry reused before the pointer
    do_req(pool_addr(0), 1'b1, pool_addr(8), 1'b1, rand_line(), 0);
    do_req(pool_addr(4), 1'b0, '0, 1'b0, '0, 0);
    // random traffic
    for (int n = 0; n < 400; n++) begin
      bit evv;
      a = pool_addr(int'($urandom_range(POOL - 1, 0)));
      evv = ($urandom_range(9, 0) < 8);
      do_req(a, evv, evv ? pick_ev(a) : '0, 1'($urandom()), rand_line(),
             int'($urandom_range(2, 0)));
    end
    // R9: plant a duplicate tag and look it up
    dsl = ins_slot_of();
    x = '0;
    for (int i = 0; i < N; i++) if (m_v[i] && i != dsl) x = m_a[i];
    a = VC_ADDR_W'(32'h2FFF);
    do_req(a, 1'b1, x, 1'b0, rand_line(), 0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = x; ev_valid = 1'b0;
    #1;
    chk(dup_err == 1'b1, "R9 duplicate match flag", VC_DATA_W'(dup_err), 1);
    req_valid = 1'b0;
    #1;
    chk(dup_err == 1'b0, "R9 flag needs a request", VC_DATA_W'(dup_err), 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule